// File: doc/BRIEF.md
# Receive CRC Checker with Per-Byte Inclusion

This block keeps a running 16-bit cyclic redundancy check over a received serial bit stream. It sits behind the receive framing logic and sees one data bit per strobe, least significant bit of each byte first. A status flag tells the receiver whether the register currently holds the residue that a correctly received frame leaves behind, so the flag can be read when a frame ends.

Two stream types are handled. In byte-synchronous mode, the controlling logic picks the polynomial, either CRC-16 or CCITT. Each assembled byte waits in a one-byte delay stage before it can reach the CRC. This gives the host a full byte time to decide whether the byte counts, for example to skip sync or control characters. In bit-oriented mode every bit goes straight into the register under the CCITT polynomial, and the select input and the include control have no effect. A start strobe at hunt or frame start loads the chosen preset and discards any partly assembled or delayed byte.

Top module: `crc_rx_check`

## Requirements
- R1: After reset, `crc` is 0x0000, and no byte is held in assembly or in the delay stage.
- R2: A cycle with `start` high loads `crc` with 0xFFFF when `preset_ones` is 1, or with 0x0000 when it is 0. The same cycle empties the byte assembly and the delay stage.
- R3: In byte-synchronous mode (`mode_bit`=0), `poly_sel`=0 selects CRC-16 (x^16+x^15+x^2+1, reflected mask 0xA001) and `poly_sel`=1 selects CCITT (x^16+x^12+x^5+1, reflected mask 0x8408). Bits are taken least significant first, and bit 0 of the received byte is the first bit received.
- R4: In bit-oriented mode (`mode_bit`=1), each strobed bit updates `crc` with the CCITT polynomial in the cycle after its strobe, whatever `poly_sel` and `byte_incl` are.
- R5: In byte-synchronous mode, a byte reaches `crc` only on the strobe that completes the following byte. On every other strobe `crc` does not change.
- R6: `byte_incl` is sampled on the strobe on which a delayed byte leaves the delay stage. If it is 0, that byte is dropped and `crc` does not change.
- R7: `crc_good` is 1 exactly when `crc` equals 0xF0B8 while the polynomial in use is CCITT, or equals 0x0000 while it is CRC-16.
- R8: When `start` and `bit_valid` are high in the same cycle, `start` wins and the bit is discarded.
- R9: In a cycle with both `bit_valid` and `start` low, `crc` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load the preset and clear byte assembly and the delay stage |
| preset_ones | input | 1 | Preset value: 1 selects all ones, 0 selects all zeros |
| mode_bit | input | 1 | 1 selects bit-oriented mode, 0 selects byte-synchronous mode |
| poly_sel | input | 1 | Byte-synchronous polynomial: 0 selects CRC-16, 1 selects CCITT |
| bit_valid | input | 1 | Strobe for one received bit |
| bit_in | input | 1 | Received data bit |
| byte_incl | input | 1 | Include decision for the byte leaving the delay stage |
| crc | output | 16 | Current CRC register |
| crc_good | output | 1 | Register holds the residue of a good frame |

## Verification
The hardest case to reach is a byte leaving the delay stage while the host has marked it for exclusion. That exit happens only on the eighth strobe of the next byte, so the include level has to be set a whole byte ahead of the data it governs. The bench therefore drives the include decision for the previous byte while it sends each byte. It excludes a leading sync character and one byte in mid-frame, and it drops a partly assembled byte by raising `start` on the same cycle as a strobe. A reference model checks `crc` and `crc_good` on every clock. Full frames carry known check values, so the good-residue flag is shown both set and cleared.

// File: rtl/crc_rx_pkg.sv
package crc_rx_pkg;
  localparam int          CRC_W       = 16;
  localparam int          BYTE_W      = 8;
  localparam int          WORD_MAX    = 32;
  localparam logic [15:0] MASK_C16    = 16'hA001;
  localparam logic [15:0] MASK_CCITT  = 16'h8408;
  localparam logic [15:0] RESID_C16   = 16'h0000;
  localparam logic [15:0] RESID_CCITT = 16'hF0B8;

  typedef enum logic {POLY_C16 = 1'b0, POLY_CCITT = 1'b1} poly_e;

  // one reflected (LSB-first) shift step
  function automatic logic [CRC_W-1:0] crc_bit(input logic [CRC_W-1:0] c,
                                               input logic b, input poly_e p);
    logic [CRC_W-1:0] r;
    logic fb;
    fb = c[0] ^ b;
    r  = c >> 1;
    if (fb) r = r ^ ((p == POLY_CCITT) ? MASK_CCITT : MASK_C16);
    return r;
  endfunction

  // n bits of d, bit 0 first
  function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c,
                                                input logic [WORD_MAX-1:0] d,
                                                input int n, input poly_e p);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < WORD_MAX; i++)
      if (i < n) r = crc_bit(r, d[i], p);
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] residue_of(input poly_e p);
    return (p == POLY_CCITT) ? RESID_CCITT : RESID_C16;
  endfunction
endpackage

// File: rtl/crc_rx_assembler.sv
module crc_rx_assembler #(
  parameter int BYTE_W = crc_rx_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val
);
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] sh_next;

  assign sh_next   = {bit_in, sh_q[BYTE_W-1:1]};
  assign byte_done = shift_en && (cnt_q == LAST);
  assign byte_val  = sh_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (shift_en) begin
      sh_q  <= sh_next;
      cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/crc_rx_delay.sv
module crc_rx_delay #(
  parameter int BYTE_W = crc_rx_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              out_fire,
  output logic [BYTE_W-1:0] dout
);
  logic              full_q;
  logic [BYTE_W-1:0] hold_q;

  assign out_fire = load && full_q;
  assign dout     = hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (clr) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (load) begin
      full_q <= 1'b1;
      hold_q <= din;
    end
  end
endmodule

// File: rtl/crc_rx_engine.sv
module crc_rx_engine
  import crc_rx_pkg::*;
#(
  parameter int BYTE_W = crc_rx_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              preset_ones,
  input  logic              bit_step,
  input  logic              bit_in,
  input  logic              byte_step,
  input  logic [BYTE_W-1:0] byte_in,
  input  poly_e             poly,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      crc_q <= '0;
    else if (init)
      crc_q <= preset_ones ? '1 : '0;
    else if (bit_step)
      crc_q <= crc_bit(crc_q, bit_in, poly);
    else if (byte_step)
      crc_q <= crc_word(crc_q, WORD_MAX'(byte_in), BYTE_W, poly);
  end

  assign crc = crc_q;
endmodule

// File: rtl/crc_rx_check.sv
module crc_rx_check
  import crc_rx_pkg::*;
#(
  parameter int BYTE_W = crc_rx_pkg::BYTE_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        preset_ones,
  input  logic        mode_bit,
  input  logic        poly_sel,
  input  logic        bit_valid,
  input  logic        bit_in,
  input  logic        byte_incl,
  output logic [15:0] crc,
  output logic        crc_good
);
  poly_e             poly_eff;
  logic              bit_step;
  logic              asm_shift;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              byte_out_fire;
  logic [BYTE_W-1:0] byte_out;
  logic              byte_step;
  logic [CRC_W-1:0]  crc_w;

  // bit-oriented mode forces CCITT
  assign poly_eff  = (mode_bit || poly_sel) ? POLY_CCITT : POLY_C16;
  assign bit_step  = bit_valid && mode_bit && !start;
  assign asm_shift = bit_valid && !mode_bit && !start;
  assign byte_step = byte_out_fire && byte_incl;

  crc_rx_assembler #(.BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .clr(start), .shift_en(asm_shift),
    .bit_in(bit_in), .byte_done(byte_done), .byte_val(byte_val)
  );

  crc_rx_delay #(.BYTE_W(BYTE_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(start), .load(byte_done),
    .din(byte_val), .out_fire(byte_out_fire), .dout(byte_out)
  );

  crc_rx_engine #(.BYTE_W(BYTE_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .init(start), .preset_ones(preset_ones),
    .bit_step(bit_step), .bit_in(bit_in), .byte_step(byte_step),
    .byte_in(byte_out), .poly(poly_eff), .crc(crc_w)
  );

  assign crc      = crc_w;
  assign crc_good = (crc_w == residue_of(poly_eff));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !start) |=> $stable(crc));

  p_start_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (crc == ($past(preset_ones) ? 16'hFFFF : 16'h0000)));

  p_excl_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_out_fire && !byte_incl && !start) |=> $stable(crc));

  p_byte_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !mode_bit && !start && !byte_done) |=> $stable(crc));

  p_fire_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_out_fire |-> byte_done);

  p_bitmode_nofire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_bit |-> !byte_out_fire);

  p_start_drops_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !byte_done);
endmodule

// File: tb/test_crc_rx_check.sv
`timescale 1ns/1ps
module test_crc_rx_check;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, preset_ones = 1'b0, mode_bit = 1'b0;
  logic poly_sel = 1'b0, bit_valid = 1'b0, bit_in = 1'b0, byte_incl = 1'b0;
  logic [15:0] crc;
  logic crc_good;

  crc_rx_check i_crc_rx_check (
    .clk(clk), .rst_n(rst_n), .start(start), .preset_ones(preset_ones),
    .mode_bit(mode_bit), .poly_sel(poly_sel), .bit_valid(bit_valid),
    .bit_in(bit_in), .byte_incl(byte_incl), .crc(crc), .crc_good(crc_good)
  );

  int total = 0, bad = 0;
  string tag = "R1";
  logic [15:0] m_crc = 16'h0;
  int m_cnt = 0;
  logic [7:0] m_cur = 8'h0, m_hold = 8'h0;
  bit m_full = 0;
  logic [15:0] snap;

  function automatic logic [15:0] ref_step(logic [15:0] c, logic b, bit ccitt);
    logic [15:0] r;
    r = {1'b0, c[15:1]};
    if (c[0] != b) r = r ^ (ccitt ? 16'h8408 : 16'hA001);
    return r;
  endfunction

  task automatic chk(string t, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic tick();
    bit ccitt;
    logic [15:0] res;
    @(posedge clk);
    if (start) begin
      m_crc = preset_ones ? 16'hFFFF : 16'h0000;
      m_cnt = 0; m_cur = 8'h0; m_full = 0;
    end else if (bit_valid) begin
      if (mode_bit) m_crc = ref_step(m_crc, bit_in, 1);
      else begin
        m_cur[m_cnt] = bit_in;
        m_cnt++;
        if (m_cnt == 8) begin
          if (m_full && byte_incl)
            for (int k = 0; k < 8; k++) m_crc = ref_step(m_crc, m_hold[k], poly_sel);
          m_hold = m_cur; m_full = 1; m_cur = 8'h0; m_cnt = 0;
        end
      end
    end
    @(negedge clk);
    ccitt = mode_bit || poly_sel;
    res = ccitt ? 16'hF0B8 : 16'h0000;
    chk({tag, " crc"}, crc, m_crc);
    chk({"R7 good"}, {15'h0, crc_good}, {15'h0, m_crc == res});
  endtask

  task automatic send_bit(logic b);
    bit_valid = 1'b1; bit_in = b;
    tick();
    bit_valid = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v, logic incl_prev);
    byte_incl = incl_prev;
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_bits_of(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic do_start();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  logic [7:0] msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
  bit finished = 0;

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset crc", crc, 16'h0000);
    chk("R1 reset good", {15'h0, crc_good}, 16'h1);

    // R3/R5/R6: CRC-16, sync byte excluded, check value 0xBB3D
    tag = "R3"; mode_bit = 0; poly_sel = 0; preset_ones = 0;
    do_start();
    chk("R2 zero preset", crc, 16'h0000);
    send_byte(8'h16, 1'b0);
    send_byte(msg[0], 1'b0);
    chk("R6 sync excluded", crc, 16'h0000);
    send_byte(msg[1], 1'b1);
    chk("R5 first byte applied one byte late", crc, ref_step(ref_step(ref_step(ref_step(
      ref_step(ref_step(ref_step(ref_step(16'h0, 1, 0), 0, 0), 0, 0), 0, 0), 1, 0), 1, 0), 0, 0), 0, 0));
    for (int i = 2; i < 9; i++) send_byte(msg[i], 1'b1);
    tag = "R9"; repeat (4) tick();
    tag = "R3";
    send_byte(8'h3D, 1'b1);
    chk("R3 crc16 check value", crc, 16'hBB3D);
    send_byte(8'hBB, 1'b1);
    send_byte(8'h00, 1'b1);
    chk("R7 crc16 residue", crc, 16'h0000);
    chk("R7 crc16 good", {15'h0, crc_good}, 16'h1);

    // CCITT byte mode, ones preset, complemented FCS
    poly_sel = 1; preset_ones = 1;
    do_start();
    chk("R2 ones preset", crc, 16'hFFFF);
    send_byte(msg[0], 1'b0);
    for (int i = 1; i < 9; i++) send_byte(msg[i], 1'b1);
    send_byte(8'h6E, 1'b1);
    chk("R3 ccitt register", crc, 16'h6F91);
    send_byte(8'h90, 1'b1);
    send_byte(8'hA5, 1'b1);
    chk("R7 ccitt residue", crc, 16'hF0B8);
    chk("R7 ccitt good", {15'h0, crc_good}, 16'h1);

    // R6: mid-frame exclusion leaves crc unchanged
    tag = "R6";
    send_byte(8'h5A, 1'b0);
    snap = crc;
    send_byte(8'hC3, 1'b0);
    chk("R6 excluded byte no change", crc, snap);
    send_byte(8'h11, 1'b1);
    chk("R7 corrupted frame not good", {15'h0, crc_good}, 16'h0);

    // R8: start wins over a strobe, partial byte dropped
    tag = "R8"; poly_sel = 0; preset_ones = 0;
    send_bit(1); send_bit(0); send_bit(1);
    start = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
    tick();
    start = 1'b0; bit_valid = 1'b0;
    chk("R8 start beats strobe", crc, 16'h0000);
    send_byte(8'hFF, 1'b1);
    send_byte(8'h01, 1'b1);
    chk("R8 fresh alignment", crc, 16'h4040);

    // R4: bit mode forces CCITT, no delay, include ignored
    tag = "R4"; mode_bit = 1; poly_sel = 0; preset_ones = 1;
    do_start();
    byte_incl = 1'b0;
    for (int i = 0; i < 9; i++) send_bits_of(msg[i]);
    chk("R4 bit mode immediate ccitt", crc, 16'h6F91);
    send_bits_of(8'h6E); send_bits_of(8'h90);
    chk("R4 bit mode residue", crc, 16'hF0B8);
    chk("R4 bit mode good", {15'h0, crc_good}, 16'h1);
    tag = "R9"; snap = crc; repeat (5) tick();
    chk("R9 idle hold", crc, snap);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule